// File: doc/BRIEF.md
# Two-Phase Logic Self-Test Sequencer

This controller runs a built-in self-test over two combinational blocks placed in a cascade. The first block sits between register A and register B, and the second sits between register B and register C. The sequencer has no datapath of its own. It only tells each of the three multi-mode registers how to behave in each cycle. The registers can hold, generate pseudo-random patterns, compress responses into a signature, or shift as one scan chain. Register B is used twice: it collects the signature of the first block, and it then becomes the pattern source for the second block.

A single `start` pulse launches a run. The run has two halves. Each half has three steps: one preparation cycle, in which the source register loads the seed and the signature register clears; a generation window of `N_PATTERNS` cycles; and a scan window of `3*REG_W` cycles. During the scan window the sequencer watches the chain's serial output. It keeps only the bits that belong to the register holding the signature and compares that word with a golden input. At the end of the run `done` rises, and the two verdicts can be read.

The control states are IDLE, PREP_A, GEN_A, SHIFT_A, PREP_B, GEN_B, SHIFT_B and DONE. The transitions are:
- IDLE or DONE to PREP_A on an accepted start.
- PREP_A to GEN_A after one cycle.
- GEN_A to SHIFT_A after `N_PATTERNS` cycles.
- SHIFT_A to PREP_B after `3*REG_W` cycles.
- PREP_B to GEN_B after one cycle.
- GEN_B to SHIFT_B after `N_PATTERNS` cycles.
- SHIFT_B to DONE after `3*REG_W` cycles.

Top module: `bist_sequencer`

## Requirements
- R1: After reset, all three mode outputs are HOLD (2'b00), `reg_prep` is 0, and `done`, `pass_l1` and `pass_l2` are 0. The other mode codes are PRPG = 2'b01, MISR = 2'b10 and SHIFT = 2'b11.
- R2: A start seen in IDLE or DONE gives one preparation cycle on the next cycle. In that cycle mode_r1 is PRPG, mode_r2 is MISR, mode_r3 is HOLD, `reg_prep` is 3'b011 (bit i is register i+1), and `seed_word` is the SEED parameter.
- R3: The first generation window follows the preparation cycle. It lasts exactly N_PATTERNS cycles, with mode_r1 = PRPG, mode_r2 = MISR, mode_r3 = HOLD and `reg_prep` = 0.
- R4: A scan window of exactly 3*REG_W cycles follows, with all modes SHIFT. In the k-th cycle of the window (k from 0), `scan_obs` carries chain bit k. Bits REG_W to 2*REG_W-1 are register B's signature, least significant bit first. `pass_l1` becomes 1 exactly when that word equals `golden_l1`.
- R5: Next comes one preparation cycle with mode_r1 = HOLD, mode_r2 = PRPG, mode_r3 = MISR and `reg_prep` = 3'b110.
- R6: A second generation window of exactly N_PATTERNS cycles follows, with mode_r1 = HOLD, mode_r2 = PRPG, mode_r3 = MISR and `reg_prep` = 0.
- R7: A second scan window of 3*REG_W cycles follows, with all modes SHIFT. Chain bits 0 to REG_W-1 are register C's signature, least significant bit first. `pass_l2` becomes 1 exactly when that word equals `golden_l2`. Chain bits outside the target window have no effect on either verdict.
- R8: `done` is 0 while a run is in progress. It rises on the cycle after the second scan window and stays high, with all modes HOLD, until the next start.
- R9: A start pulse during any preparation, generation or scan cycle is ignored, and the mode sequence continues unchanged.
- R10: An accepted start clears `done`, `pass_l1` and `pass_l2` in the preparation cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch request, acted on only in IDLE or DONE |
| golden_l1 | input | REG_W | Expected signature of the first block |
| golden_l2 | input | REG_W | Expected signature of the second block |
| scan_obs | input | 1 | Serial output of the register chain |
| mode_r1 | output | 2 | Mode of register A |
| mode_r2 | output | 2 | Mode of register B |
| mode_r3 | output | 2 | Mode of register C |
| reg_prep | output | 3 | Per-register strobe: load the seed (PRPG) or clear (MISR) |
| seed_word | output | REG_W | Seed value for the pattern source |
| done | output | 1 | Run finished; verdicts are valid |
| pass_l1 | output | 1 | First block's signature matched |
| pass_l2 | output | 1 | Second block's signature matched |

## Verification
The properties assume that `start` is a synchronous single-bit level and that the golden words stay stable from launch until `done`. They also assume the chain shifts exactly one bit per SHIFT cycle, so that scan bit k appears in the k-th window cycle. The bench meets these assumptions by driving every input on the falling edge and keeping the golden words fixed for the whole run. It models the chain by presenting chain bit k in window cycle k. The non-target chain bits are filled with random values, and launch attempts are injected at random points inside a run.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;

    localparam int NUM_REGS = 3;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_PRPG  = 2'b01,
        MODE_MISR  = 2'b10,
        MODE_SHIFT = 2'b11
    } reg_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP_A,
        ST_GEN_A,
        ST_SHIFT_A,
        ST_PREP_B,
        ST_GEN_B,
        ST_SHIFT_B,
        ST_DONE
    } seq_state_e;

    // Role of register idx (0 = A, 1 = B, 2 = C) in a given control state.
    function automatic reg_mode_e role_of(seq_state_e st, int idx);
        reg_mode_e m;
        m = MODE_HOLD;
        unique case (st)
            ST_PREP_A, ST_GEN_A: begin
                if (idx == 0)      m = MODE_PRPG;
                else if (idx == 1) m = MODE_MISR;
            end
            ST_PREP_B, ST_GEN_B: begin
                if (idx == 1)      m = MODE_PRPG;
                else if (idx == 2) m = MODE_MISR;
            end
            ST_SHIFT_A, ST_SHIFT_B: m = MODE_SHIFT;
            default:                m = MODE_HOLD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bist_phase_counter.sv
module bist_phase_counter #(
    parameter int CW        = 9,
    parameter int GEN_LEN   = 255,
    parameter int SHIFT_LEN = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt,
    output logic          gen_last,
    output logic          shift_last
);

    localparam logic [CW-1:0] GEN_END   = CW'(GEN_LEN - 1);
    localparam logic [CW-1:0] SHIFT_END = CW'(SHIFT_LEN - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end

    assign gen_last   = (cnt == GEN_END);
    assign shift_last = (cnt == SHIFT_END);

endmodule

// File: rtl/bist_sig_window.sv
module bist_sig_window #(
    parameter int W  = 16,
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] ofs,
    input  logic [CW-1:0] cnt,
    input  logic          scan_bit,
    output logic [W-1:0]  cap
);

    logic [CW-1:0] win_hi;
    logic          in_win;

    assign win_hi = ofs + CW'(W);
    assign in_win = en && (cnt >= ofs) && (cnt < win_hi);

    // The first bit seen ends up in cap[0] after W shifts.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cap <= '0;
        else if (in_win) cap <= {scan_bit, cap[W-1:1]};
    end

endmodule

// File: rtl/bist_seq_ctrl.sv
module bist_seq_ctrl
    import bist_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       gen_last,
    input  logic       shift_last,
    output seq_state_e state,
    output logic       launch,
    output logic       cnt_clr,
    output logic       prep_phase,
    output logic       shift_phase,
    output logic       target_b,
    output logic       cmp_a,
    output logic       cmp_b,
    output logic       done
);

    seq_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start)      nxt = ST_PREP_A;
            ST_PREP_A:                  nxt = ST_GEN_A;
            ST_GEN_A:   if (gen_last)   nxt = ST_SHIFT_A;
            ST_SHIFT_A: if (shift_last) nxt = ST_PREP_B;
            ST_PREP_B:                  nxt = ST_GEN_B;
            ST_GEN_B:   if (gen_last)   nxt = ST_SHIFT_B;
            ST_SHIFT_B: if (shift_last) nxt = ST_DONE;
            ST_DONE:    if (start)      nxt = ST_PREP_A;
            default:                    nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        launch      = 1'b0;
        cnt_clr     = 1'b0;
        prep_phase  = 1'b0;
        shift_phase = 1'b0;
        target_b    = 1'b0;
        cmp_a       = 1'b0;
        cmp_b       = 1'b0;
        done        = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cnt_clr = 1'b1;
                launch  = start;
            end
            ST_PREP_A, ST_PREP_B: begin
                cnt_clr    = 1'b1;
                prep_phase = 1'b1;
            end
            ST_GEN_A, ST_GEN_B: cnt_clr = gen_last;
            ST_SHIFT_A: begin
                shift_phase = 1'b1;
                target_b    = 1'b1;
                cmp_a       = shift_last;
            end
            ST_SHIFT_B: begin
                shift_phase = 1'b1;
                cmp_b       = shift_last;
            end
            ST_DONE: begin
                cnt_clr = 1'b1;
                done    = 1'b1;
                launch  = start;
            end
            default: cnt_clr = 1'b1;
        endcase
    end

endmodule

// File: rtl/bist_sequencer.sv
module bist_sequencer
    import bist_seq_pkg::*;
#(
    parameter int               REG_W      = 16,
    parameter int               N_PATTERNS = 255,
    parameter logic [REG_W-1:0] SEED       = REG_W'(32'h0000ACE1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REG_W-1:0] golden_l1,
    input  logic [REG_W-1:0] golden_l2,
    input  logic             scan_obs,
    output logic [1:0]       mode_r1,
    output logic [1:0]       mode_r2,
    output logic [1:0]       mode_r3,
    output logic [2:0]       reg_prep,
    output logic [REG_W-1:0] seed_word,
    output logic             done,
    output logic             pass_l1,
    output logic             pass_l2
);

    localparam int CHAIN_LEN = NUM_REGS * REG_W;
    localparam int CNT_MAX   = (N_PATTERNS > CHAIN_LEN) ? N_PATTERNS : CHAIN_LEN;
    localparam int CW        = $clog2(CNT_MAX + 1);
    // The chain drains C first, then B, then A.
    localparam logic [CW-1:0] OFS_B = CW'(REG_W);
    localparam logic [CW-1:0] OFS_C = CW'(0);

    seq_state_e       state;
    logic             launch, cnt_clr, prep_phase, shift_phase, target_b;
    logic             cmp_a, cmp_b, gen_last, shift_last;
    logic [CW-1:0]    cnt;
    logic [REG_W-1:0] cap;
    logic [1:0]       mode_vec [NUM_REGS];

    bist_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .gen_last    (gen_last),
        .shift_last  (shift_last),
        .state       (state),
        .launch      (launch),
        .cnt_clr     (cnt_clr),
        .prep_phase  (prep_phase),
        .shift_phase (shift_phase),
        .target_b    (target_b),
        .cmp_a       (cmp_a),
        .cmp_b       (cmp_b),
        .done        (done)
    );

    bist_phase_counter #(
        .CW        (CW),
        .GEN_LEN   (N_PATTERNS),
        .SHIFT_LEN (CHAIN_LEN)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (cnt_clr),
        .cnt        (cnt),
        .gen_last   (gen_last),
        .shift_last (shift_last)
    );

    bist_sig_window #(
        .W  (REG_W),
        .CW (CW)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (shift_phase),
        .ofs      (target_b ? OFS_B : OFS_C),
        .cnt      (cnt),
        .scan_bit (scan_obs),
        .cap      (cap)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_role
        assign mode_vec[g] = role_of(state, g);
        assign reg_prep[g] = prep_phase && (mode_vec[g] != MODE_HOLD);
    end

    assign mode_r1   = mode_vec[0];
    assign mode_r2   = mode_vec[1];
    assign mode_r3   = mode_vec[2];
    assign seed_word = SEED;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_l1 <= 1'b0;
            pass_l2 <= 1'b0;
        end else if (launch) begin
            pass_l1 <= 1'b0;
            pass_l2 <= 1'b0;
        end else begin
            if (cmp_a) pass_l1 <= (cap == golden_l1);
            if (cmp_b) pass_l2 <= (cap == golden_l2);
        end
    end

endmodule

// File: rtl/bist_sequencer_chk.sv
module bist_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [1:0] mode_r1,
    input logic [1:0] mode_r2,
    input logic [1:0] mode_r3,
    input logic [2:0] reg_prep,
    input logic       done,
    input logic       pass_l1,
    input logic       pass_l2
);

    // R1/R2/R5: strobes occur only in the two legal preparation patterns
    p_prep_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_prep != 3'b000) |->
            ((reg_prep == 3'b011 && mode_r1 == 2'b01 && mode_r2 == 2'b10 && mode_r3 == 2'b00) ||
             (reg_prep == 3'b110 && mode_r1 == 2'b00 && mode_r2 == 2'b01 && mode_r3 == 2'b10)));

    // R3: a first preparation cycle is followed by phase-one generation
    p_prep_to_gen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_prep == 3'b011) |=> (reg_prep == 3'b000 && mode_r1 == 2'b01 && mode_r2 == 2'b10));

    // R6: a second preparation cycle is followed by phase-two generation
    p_prep_to_gen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_prep == 3'b110) |=> (reg_prep == 3'b000 && mode_r2 == 2'b01 && mode_r3 == 2'b10));

    // R4/R7: scan is chain-wide, never partial
    p_scan_whole_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_r1 == 2'b11 || mode_r2 == 2'b11 || mode_r3 == 2'b11) |->
            (mode_r1 == 2'b11 && mode_r2 == 2'b11 && mode_r3 == 2'b11));

    // R8: done implies every register is idle
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mode_r1 == 2'b00 && mode_r2 == 2'b00 && mode_r3 == 2'b00 && reg_prep == 3'b000));

    // R8: done persists until a start
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R9: a start during generation of phase one does not relaunch
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && reg_prep == 3'b000 && mode_r1 == 2'b01) |=> (reg_prep != 3'b011));

    // R10: verdicts move only after a scan window or on a launch
    p_pass_l1_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pass_l1) |-> ($past(mode_r1) == 2'b11 || $past(start)));

    p_pass_l2_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pass_l2) |-> ($past(mode_r1) == 2'b11 || $past(start)));

endmodule

bind bist_sequencer bist_sequencer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode_r1  (mode_r1),
    .mode_r2  (mode_r2),
    .mode_r3  (mode_r3),
    .reg_prep (reg_prep),
    .done     (done),
    .pass_l1  (pass_l1),
    .pass_l2  (pass_l2)
);

// File: tb/sim_bist_sequencer.sv
module sim_bist_sequencer;

    localparam int PERIOD = 10;
    localparam int W      = 16;
    localparam int NPAT   = 255;
    localparam int CH     = 3 * W;
    localparam int HALF   = 1 + NPAT + CH;
    localparam int TOTAL  = 2 * HALF;
    localparam logic [W-1:0] SEED_V = 16'hACE1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] golden_l1 = '0;
    logic [W-1:0] golden_l2 = '0;
    logic         scan_obs = 1'b0;
    logic [1:0]   mode_r1, mode_r2, mode_r3;
    logic [2:0]   reg_prep;
    logic [W-1:0] seed_word;
    logic         done, pass_l1, pass_l2;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #(PERIOD / 2) clk = ~clk;

    bist_sequencer #(.REG_W(W), .N_PATTERNS(NPAT), .SEED(SEED_V)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .golden_l1(golden_l1), .golden_l2(golden_l2), .scan_obs(scan_obs),
        .mode_r1(mode_r1), .mode_r2(mode_r2), .mode_r3(mode_r3),
        .reg_prep(reg_prep), .seed_word(seed_word),
        .done(done), .pass_l1(pass_l1), .pass_l2(pass_l2)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pack_modes(logic [1:0] a, logic [1:0] b, logic [1:0] c, logic [2:0] p);
        return {a, b, c, p[1:0]} ^ {7'd0, p[2]};
    endfunction

    // Expected {mode_r1, mode_r2, mode_r3, prep} for run cycle t
    function automatic logic [8:0] exp_ctl(int t);
        int p, u;
        p = (t < HALF) ? 0 : 1;
        u = t - p * HALF;
        if (u > NPAT) return {2'b11, 2'b11, 2'b11, 3'b000};
        if (p == 0)   return {2'b01, 2'b10, 2'b00, (u == 0) ? 3'b011 : 3'b000};
        return {2'b00, 2'b01, 2'b10, (u == 0) ? 3'b110 : 3'b000};
    endfunction

    function automatic string req_of(int t);
        int p, u;
        p = (t < HALF) ? 0 : 1;
        u = t - p * HALF;
        if (u == 0)    return (p == 0) ? "R2" : "R5";
        if (u <= NPAT) return (p == 0) ? "R3" : "R6";
        return (p == 0) ? "R4" : "R7";
    endfunction

    task automatic run_one(input logic [W-1:0] s1, input logic [W-1:0] s2,
                           input logic [W-1:0] g1, input logic [W-1:0] g2, input int inj_at);
        bit       bad_seq;
        bit       bad_done;
        bit       bad_seed;
        logic [8:0] act;
        logic [8:0] exp;
        string    bad_req;
        logic [8:0] bad_act;
        logic [8:0] bad_exp;
        bad_seq = 1'b0; bad_done = 1'b0; bad_seed = 1'b0;
        bad_req = ""; bad_act = '0; bad_exp = '0;
        golden_l1 = g1;
        golden_l2 = g2;
        start = 1'b1;
        @(negedge clk);
        // R10: the launch cleared status
        check(done == 1'b0 && pass_l1 == 1'b0 && pass_l2 == 1'b0, "R10",
              {61'd0, done, pass_l1, pass_l2}, 64'd0);
        for (int t = 0; t < TOTAL; t++) begin
            int p, u, k, ofs;
            logic [W-1:0] sig;
            act = {mode_r1, mode_r2, mode_r3, reg_prep};
            exp = exp_ctl(t);
            if (act != exp && !bad_seq) begin
                bad_seq = 1'b1; bad_req = req_of(t); bad_act = act; bad_exp = exp;
            end
            if (done) bad_done = 1'b1;
            if (reg_prep != 3'b000 && seed_word != SEED_V) bad_seed = 1'b1;
            p = (t < HALF) ? 0 : 1;
            u = t - p * HALF;
            k = u - 1 - NPAT;
            ofs = (p == 0) ? W : 0;
            sig = (p == 0) ? s1 : s2;
            if (u > NPAT && k >= ofs && k < ofs + W) scan_obs = sig[k - ofs];
            else                                       scan_obs = 1'($urandom);
            start = (t == inj_at);
            @(negedge clk);
        end
        start = 1'b0;
        check(!bad_seq, (inj_at >= 0) ? {bad_req, "/R9"} : bad_req, 64'(bad_act), 64'(bad_exp));
        check(!bad_done, "R8", 64'(bad_done), 64'd0);
        check(!bad_seed, "R2", 64'(seed_word), 64'(SEED_V));
        check(done == 1'b1 && mode_r1 == 2'b00 && mode_r2 == 2'b00 && mode_r3 == 2'b00,
              "R8", {56'd0, done, mode_r1, mode_r2, mode_r3, 1'b0}, {56'd0, 8'b1000_0000});
        check(pass_l1 == (s1 == g1), "R4", 64'(pass_l1), 64'(s1 == g1));
        check(pass_l2 == (s2 == g2), "R7", 64'(pass_l2), 64'(s2 == g2));
        repeat (5) @(negedge clk);
        check(done == 1'b1 && pass_l1 == (s1 == g1) && pass_l2 == (s2 == g2), "R8",
              {61'd0, done, pass_l1, pass_l2}, {61'd0, 1'b1, s1 == g1, s2 == g2});
    endtask

    initial begin
        logic [W-1:0] a, b;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset values
        check(mode_r1 == 2'b00 && mode_r2 == 2'b00 && mode_r3 == 2'b00 && reg_prep == 3'b000,
              "R1", 64'({mode_r1, mode_r2, mode_r3, reg_prep}), 64'd0);
        check(done == 1'b0 && pass_l1 == 1'b0 && pass_l2 == 1'b0, "R1",
              64'({done, pass_l1, pass_l2}), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(mode_r1 == 2'b00 && done == 1'b0, "R1", 64'({mode_r1, done}), 64'd0);

        // Directed cases
        a = 16'h5A3C; b = 16'hC001;
        run_one(a, b, a, b, -1);
        run_one(a, b, a ^ 16'h0001, b, -1);             // R4 LSB mismatch
        run_one(a, b, a, b ^ 16'h8000, -1);             // R7 MSB mismatch
        run_one(16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF, 0);  // R9 start in first prep cycle
        run_one(a, b, a, b, TOTAL - 1);                 // R9 start in last scan cycle

        // Random cases with injected starts
        for (int r = 0; r < 6; r++) begin
            logic [W-1:0] s1, s2, g1, g2;
            s1 = W'($urandom); s2 = W'($urandom);
            g1 = ($urandom_range(0, 1) == 0) ? s1 : s1 ^ (W'(1) << $urandom_range(0, W - 1));
            g2 = ($urandom_range(0, 1) == 0) ? s2 : s2 ^ (W'(1) << $urandom_range(0, W - 1));
            run_one(s1, s2, g1, g2, (r % 2 == 0) ? $urandom_range(1, TOTAL - 1) : -1);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule